// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

The block divides a fast input clock by a 17-bit ratio. It uses the classic pulse-swallow arrangement. A dual-modulus prescaler stage counts 16 or 17 input clocks per step. A 13-bit main counter sets how many prescaler steps make one output period. A 4-bit swallow counter sets how many of those steps use the longer 17-clock modulus. The prescaler is modelled as a digital counter, so every register runs on the input clock.

Software writes a ratio word through the control interface and pulses a load strobe. The word is captured at once, but the counters pick it up only at the next output period boundary. A period that has already started always runs to completion with its old ratio, so the tuning step never shortens or stretches a period. The block gives a one-clock pulse per output period, plus a divided-by-two square wave that can be routed to a test pin.

Top module: `pulse_swallow_div`

## Requirements
- R1: Between consecutive rising edges of `div_o` there are exactly R input clock cycles. R is the loaded ratio and ranges from 240 to 131071.
- R2: The ratio decomposes as R = 16·M + A, with M = `ratio_i[16:4]` and A = `ratio_i[3:0]`. The period is correct for every value of A from 0 to 15, including A = M (R = 255).
- R3: A loaded ratio below 240, including 0, is treated as 240.
- R4: A ratio loaded during an output period takes effect from the next period onward, and the current period keeps the old ratio. The exception is a load sampled on the same clock edge that raises `div_o`: it first takes effect one period later.
- R5: While `load_i` is low, changes on `ratio_i` have no effect on the period.
- R6: `div_o` is high for exactly one clock cycle per output period.
- R7: `div2_o` changes level on exactly the clock edge that raises `div_o`, and on no other edge.
- R8: After reset, `div_o` and `div2_o` are low, and the divider runs at ratio 240 until the first load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 17 | Division ratio word (M in bits 16:4, A in bits 3:0) |
| load_i | input | 1 | Captures `ratio_i` on the clock edge where it is high |
| div_o | output | 1 | One-clock pulse at the end of each output period |
| div2_o | output | 1 | Output period divided by two, for test observation |

## Verification
Any fault in the internal state shows up as a period error at `div_o` by the end of the period in which it occurs. This covers a prescaler that keeps the wrong modulus, a swallow count that is off by one, and a reload taken from the wrong register. Each of these adds or removes a multiple of one or sixteen clocks from that period. A load applied at the wrong moment shows up as a wrong length in the period around the load. The bench therefore loads at several points in the period, including the edge before and the edge of the terminal count. A stuck or double toggle of `div2_o` is caught at the first pulse.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned DEF_A_W       = 4;
  localparam int unsigned DEF_M_W       = 13;
  localparam int unsigned DEF_MIN_RATIO = 240;
endpackage

// File: rtl/psd_ratio_hold.sv
module psd_ratio_hold #(
  parameter int unsigned A_W       = 4,
  parameter int unsigned M_W       = 13,
  parameter int unsigned MIN_RATIO = 240,
  localparam int unsigned RATIO_W  = M_W + A_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  output logic [M_W-1:0]     pend_m_o,
  output logic [A_W-1:0]     pend_a_o
);
  localparam logic [RATIO_W-1:0] MIN_W = RATIO_W'(MIN_RATIO);

  logic [RATIO_W-1:0] pend_q, clamped;

  // floor keeps M >= A so the swallow count always fits inside a frame
  assign clamped = (ratio_i < MIN_W) ? MIN_W : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= MIN_W;
    else if (load_i) pend_q <= clamped;
  end

  assign pend_m_o = pend_q[RATIO_W-1:A_W];
  assign pend_a_o = pend_q[A_W-1:0];

  // R3
  pend_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q >= MIN_W);

  // R5
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(pend_q));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned A_W = 4,
  localparam int unsigned P_LOW = 1 << A_W,
  localparam int unsigned PC_W  = $clog2(P_LOW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  output logic tc_o
);
  logic [PC_W-1:0] pc_q;

  assign tc_o = long_i ? (pc_q == PC_W'(P_LOW)) : (pc_q == PC_W'(P_LOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (tc_o) pc_q <= '0;
    else           pc_q <= pc_q + PC_W'(1);
  end

  // R2
  pc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= PC_W'(P_LOW));

  // R2
  pc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> pc_q == '0);
endmodule

// File: rtl/psd_mn_counter.sv
module psd_mn_counter #(
  parameter int unsigned A_W       = 4,
  parameter int unsigned M_W       = 13,
  parameter int unsigned MIN_RATIO = 240,
  localparam int unsigned RATIO_W  = M_W + A_W,
  localparam logic [RATIO_W-1:0] MIN_W = RATIO_W'(MIN_RATIO)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tc_i,
  input  logic [M_W-1:0] pend_m_i,
  input  logic [A_W-1:0] pend_a_i,
  output logic           long_o,
  output logic           frame_end_o
);
  logic [M_W-1:0] m_q;
  logic [A_W-1:0] a_q;
  logic           last;

  assign last        = (m_q == M_W'(1));
  assign long_o      = (a_q != '0);
  assign frame_end_o = tc_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= MIN_W[RATIO_W-1:A_W];
      a_q <= MIN_W[A_W-1:0];
    end else if (tc_i) begin
      if (last) begin
        m_q <= pend_m_i;
        a_q <= pend_a_i;
      end else begin
        m_q <= m_q - M_W'(1);
        if (long_o) a_q <= a_q - A_W'(1);
      end
    end
  end

  // R2
  a_within_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    M_W'(a_q) <= m_q);

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (m_q == $past(pend_m_i)) && (a_q == $past(pend_a_i)));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int unsigned A_W       = DEF_A_W,
  parameter int unsigned M_W       = DEF_M_W,
  parameter int unsigned MIN_RATIO = DEF_MIN_RATIO,
  localparam int unsigned RATIO_W  = M_W + A_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  output logic               div_o,
  output logic               div2_o
);
  logic [M_W-1:0] pend_m;
  logic [A_W-1:0] pend_a;
  logic           long_sel, tc, frame_end;
  logic           div_q, div2_q;

  psd_ratio_hold #(.A_W(A_W), .M_W(M_W), .MIN_RATIO(MIN_RATIO)) u_hold (
    .clk_i, .rst_ni, .ratio_i, .load_i,
    .pend_m_o(pend_m), .pend_a_o(pend_a)
  );

  psd_prescaler #(.A_W(A_W)) u_pre (
    .clk_i, .rst_ni, .long_i(long_sel), .tc_o(tc)
  );

  psd_mn_counter #(.A_W(A_W), .M_W(M_W), .MIN_RATIO(MIN_RATIO)) u_mn (
    .clk_i, .rst_ni, .tc_i(tc), .pend_m_i(pend_m), .pend_a_i(pend_a),
    .long_o(long_sel), .frame_end_o(frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= 1'b0;
      div2_q <= 1'b0;
    end else begin
      div_q  <= frame_end;
      div2_q <= div2_q ^ frame_end;
    end
  end

  assign div_o  = div_q;
  assign div2_o = div2_q;

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  // R7
  div2_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (div2_o != $past(div2_o)) && div_o);

  // R7
  div2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(div2_o));
endmodule

// File: tb/pulse_swallow_div_tb.sv
module pulse_swallow_div_tb_top;
  localparam int unsigned RW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ratio = '0;
  logic          load = 1'b0;
  logic          div, div2;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_swallow_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .load_i(load),
    .div_o(div), .div2_o(div2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Measure one period ending at the next div pulse; optionally drive ratio/load at cycle ld_at.
  task automatic period(input int exp, input string req,
                        input int ld_at = 0, input int ld_val = 0, input bit ld_en = 1'b1);
    int  n = 0;
    bit  d2_ref = div2;
    bit  d2_bad = 1'b0;
    forever begin
      @(posedge clk); #1;
      n++;
      load = 1'b0;
      if (n == 1) chk(div == 1'b0, "R6", div, 0);
      if (div) break;
      if (div2 != d2_ref) d2_bad = 1'b1;
      if (n == ld_at) begin
        ratio = RW'(ld_val);
        load  = ld_en;
      end
      if (n > exp + 40) break;
    end
    chk(n == exp, req, n, exp);
    chk(!d2_bad && div2 == !d2_ref, "R7", div2, int'(!d2_ref));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cur;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk(div == 1'b0, "R8", div, 0);
    chk(div2 == 1'b0, "R8", div2, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    period(240, "R8");
    period(240, "R8");

    // R1/R2: sweep every A value, load early in period
    cur = 240;
    for (int r = 241; r <= 272; r++) begin
      period(cur, "R4", 5, r);
      period(r, "R2");
      cur = r;
    end

    // R3: clamp
    period(cur, "R4", 10, 0);
    period(240, "R3");
    period(240, "R3", 3, 239);
    period(240, "R3");
    period(240, "R3", 7, 100);
    period(240, "R3");
    cur = 240;

    // R5: ratio changes without load are ignored
    period(cur, "R5", 4, 1000, 1'b0);
    period(cur, "R5", 50, 3000, 1'b0);
    period(cur, "R5");

    // R4: load one edge before the terminal edge -> next period
    period(cur, "R4", cur - 2, 1000);
    period(1000, "R1");
    cur = 1000;
    // R4: load sampled on the pulse edge -> one period later
    period(cur, "R4", cur - 1, 777);
    period(1000, "R4");
    period(777, "R4");
    cur = 777;

    // R1: larger ratios and the upper limit
    period(cur, "R4", 20, 4097);
    period(4097, "R1");
    period(4097, "R1", 30, 131071);
    period(131071, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule